// File: doc/BRIEF.md
# Layered Write-Protection Controller

This block sits beside the storage array of a small two-wire serial memory and decides, for every array write the bus layer has decoded, whether the storage may really change. Three sources combine into the protection level: a hardware protect pin, a permanent software flag and a reversible software flag. The pin guards the whole array. Either software flag guards only the lower half of the address space. Together they give no protection, lower-half protection or full protection.

The bus layer hands over each decoded control byte (device-select nibble, three address-select bits and the R/W bit in bit 0), together with single-cycle pulses for start, stop and each received array data byte. For control bytes with upper nibble `0110` the block returns an ACK or NACK decision one cycle later. The state of the flags is reported on the bus only as that ACK/NACK. A flag change is armed by an acknowledged command and happens only at the stop that closes the frame. The two flags are held in registers that take their nonvolatile values from preload inputs while reset is active.

The command tracker is a four-state machine. **IDLE** waits for a command. **ARM_PERM**, **ARM_SETREV** and **ARM_CLRREV** hold an acknowledged set-permanent, set-reversible or clear-reversible command. The transitions are as follows. *arm*: IDLE or any armed state goes to the matching armed state on an acknowledged command byte. *drop*: a command byte that is not acknowledged, or that is not a flag-changing command, returns to IDLE. *commit*: a stop in an armed state returns to IDLE and updates the flag unless the protect pin is high. *abort*: a start in any state returns to IDLE with no change.

Top module: `wprot_ctrl`

## Requirements
- R1: While `hw_lock` is 1, `mem_we` is 0 for every address, whatever the state of the software flags.
- R2: While either flag is set and `hw_lock` is 0, a write to an address with MSB 0 (00h–7Fh) gives `mem_we`=0, and a write to an address with MSB 1 (80h–FFh) gives `mem_we`=1 in the same cycle as `wr_req`.
- R3: With both flags clear and `hw_lock` at 0, `mem_we` follows `wr_req` combinationally for every address.
- R4: Control byte `0110 f2 f1 f0 0` with `a0_hv`=0 and field f2..f0 equal to `pin_addr` is the set-permanent command. It is acknowledged while the permanent flag is clear and sets `perm_flag` at the closing stop. Nothing ever clears `perm_flag` except reset with a clear preload.
- R5: While `perm_flag` is 1, every control byte with upper nibble `0110` gets `ctl_ack_vld`=1 with `ctl_ack`=0.
- R6: Byte 62h with `a0_hv`=1 and `pin_addr[2:1]`=00 is set-reversible. It is acknowledged only when both flags are clear, and a repeat while `rev_flag` is 1 gets a NACK. It sets `rev_flag` at the closing stop.
- R7: Byte 66h with `a0_hv`=1 and `pin_addr[2:1]`=01 is clear-reversible. It is acknowledged unless `perm_flag` is 1, and it clears `rev_flag` at the closing stop.
- R8: A status read is the set command with bit 0 at 1 (63h for the reversible flag, `0110 pin_addr 1` for the permanent flag). ACK means the flag is not programmed, and NACK means it is programmed or the permanent flag is set.
- R9: An acknowledged set or clear command whose closing stop arrives while `hw_lock` is 1 still gets its ACK but leaves both flags unchanged.
- R10: Flags change only at the cycle after a `frame_stop` pulse. A frame ended by a new start, with no stop, leaves both flags unchanged, and a later lone stop commits nothing.
- R11: A `0110` byte whose address field does not match (including 67h) gets `ctl_ack_vld`=1 with `ctl_ack`=0. A byte with any other upper nibble gives `ctl_ack_vld`=0.
- R12: While `rst_n` is 0, `perm_flag` and `rev_flag` load from `preload_perm` and `preload_rev`.
- R13: `ctl_ack_vld` and `ctl_ack` are registered and are valid in the cycle after the `ctl_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads flags from preloads |
| preload_perm | input | 1 | Retained permanent-flag value |
| preload_rev | input | 1 | Retained reversible-flag value |
| hw_lock | input | 1 | Hardware protect pin level |
| a0_hv | input | 1 | High voltage present on address input 0 |
| pin_addr | input | 3 | Address-select pin levels |
| ctl_valid | input | 1 | One-cycle pulse: `ctl_byte` holds a decoded control byte |
| ctl_byte | input | 8 | Control byte: nibble, address field, R/W in bit 0 |
| frame_start | input | 1 | One-cycle pulse on start condition |
| frame_stop | input | 1 | One-cycle pulse on stop condition |
| wr_req | input | 1 | One-cycle pulse: array data byte received for `word_addr` |
| word_addr | input | 8 | Target array address |
| mem_we | output | 1 | Write enable to storage |
| ctl_ack_vld | output | 1 | ACK decision valid for a `0110` byte |
| ctl_ack | output | 1 | 1 = ACK, 0 = NACK |
| perm_flag | output | 1 | Permanent protection flag |
| rev_flag | output | 1 | Reversible protection flag |

## Verification
The bench targets the boundary between 7Fh and 80h under software protection. A design that decoded the wrong address bit would either lock the upper half or let lower-half data be overwritten. It runs a set command while the pin is high and a frame aborted by a restart, then sends a lone stop afterwards. A design that committed on the ACK, or kept a stale armed command, would change a flag there. After the permanent flag is set it sends every command form. A design that looked only at the reversible flag would still acknowledge the clear or the status read, and it would let the reversible protection be lifted.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // Upper nibble shared by all protection-register commands
    localparam logic [3:0] PROT_NIBBLE = 4'b0110;

    typedef enum logic [2:0] {
        K_NONE,      // not a protection command
        K_MISS,      // protection nibble, address field not selected
        K_SET_PERM,
        K_RD_PERM,
        K_SET_REV,
        K_RD_REV,
        K_CLR_REV
    } cmd_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM_PERM,
        ST_ARM_SETREV,
        ST_ARM_CLRREV
    } wp_state_t;

endpackage

// File: rtl/wprot_cmd_decode.sv
module wprot_cmd_decode
    import wprot_pkg::*;
#(
    parameter int PIN_W = 3,
    localparam int CTL_W = PIN_W + 5
) (
    input  logic [CTL_W-1:0] ctl_byte,
    input  logic [PIN_W-1:0] pin_addr,
    input  logic             a0_hv,
    output cmd_kind_t        kind
);

    logic [3:0]       nib;
    logic [PIN_W-1:0] fld;
    logic             rd;
    logic             hv_sel;

    assign nib = ctl_byte[CTL_W-1:CTL_W-4];
    assign fld = ctl_byte[PIN_W:1];
    assign rd  = ctl_byte[0];

    // High-voltage forms: field LSB must be 1, upper field bits and pins 0,
    // field bit 1 must agree with pin 1 (0 = set/read, 1 = clear)
    assign hv_sel = fld[0]
                 && (fld[PIN_W-1:2] == '0)
                 && (pin_addr[PIN_W-1:2] == '0)
                 && (pin_addr[1] == fld[1]);

    always_comb begin
        kind = K_NONE;
        if (nib == PROT_NIBBLE) begin
            kind = K_MISS;
            if (a0_hv) begin
                if (hv_sel) begin
                    if (!fld[1])
                        kind = rd ? K_RD_REV : K_SET_REV;
                    else if (!rd)
                        kind = K_CLR_REV;
                end
            end else if (fld == pin_addr) begin
                kind = rd ? K_RD_PERM : K_SET_PERM;
            end
        end
    end

endmodule

// File: rtl/wprot_array_gate.sv
module wprot_array_gate #(
    parameter int ADDR_W = 8
) (
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              hw_lock,
    input  logic              perm_flag,
    input  logic              rev_flag,
    output logic              mem_we
);

    logic lower_half;
    logic soft_lock;

    assign lower_half = ~word_addr[ADDR_W-1];
    assign soft_lock  = (perm_flag | rev_flag) & lower_half;
    assign mem_we     = wr_req & ~hw_lock & ~soft_lock;

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PIN_W  = 3,
    localparam int CTL_W = PIN_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preload_perm,
    input  logic              preload_rev,
    input  logic              hw_lock,
    input  logic              a0_hv,
    input  logic [PIN_W-1:0]  pin_addr,
    input  logic              ctl_valid,
    input  logic [CTL_W-1:0]  ctl_byte,
    input  logic              frame_start,
    input  logic              frame_stop,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] word_addr,
    output logic              mem_we,
    output logic              ctl_ack_vld,
    output logic              ctl_ack,
    output logic              perm_flag,
    output logic              rev_flag
);

    cmd_kind_t kind;
    logic      kind_ack;
    wp_state_t st_q, st_d;

    wprot_cmd_decode #(.PIN_W(PIN_W)) dec_i (
        .ctl_byte (ctl_byte),
        .pin_addr (pin_addr),
        .a0_hv    (a0_hv),
        .kind     (kind)
    );

    wprot_array_gate #(.ADDR_W(ADDR_W)) gate_i (
        .wr_req    (wr_req),
        .word_addr (word_addr),
        .hw_lock   (hw_lock),
        .perm_flag (perm_flag),
        .rev_flag  (rev_flag),
        .mem_we    (mem_we)
    );

    // ACK rule: permanent flag silences the whole command family
    always_comb begin
        unique case (kind)
            K_SET_PERM, K_RD_PERM, K_CLR_REV: kind_ack = ~perm_flag;
            K_SET_REV,  K_RD_REV:             kind_ack = ~perm_flag & ~rev_flag;
            default:                          kind_ack = 1'b0;
        endcase
    end

    // Next state: stop > start > command byte
    always_comb begin
        st_d = st_q;
        if (frame_stop || frame_start) begin
            st_d = ST_IDLE;
        end else if (ctl_valid) begin
            st_d = ST_IDLE;
            if (kind_ack) begin
                case (kind)
                    K_SET_PERM: st_d = ST_ARM_PERM;
                    K_SET_REV:  st_d = ST_ARM_SETREV;
                    K_CLR_REV:  st_d = ST_ARM_CLRREV;
                    default:    st_d = ST_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Retained flags, committed only at a stop with the pin low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_flag <= preload_perm;
            rev_flag  <= preload_rev;
        end else if (frame_stop && !hw_lock) begin
            unique case (st_q)
                ST_ARM_PERM:   perm_flag <= 1'b1;
                ST_ARM_SETREV: rev_flag  <= 1'b1;
                ST_ARM_CLRREV: rev_flag  <= 1'b0;
                ST_IDLE:       ;
            endcase
        end
    end

    // Registered ACK response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_ack_vld <= 1'b0;
            ctl_ack     <= 1'b0;
        end else begin
            ctl_ack_vld <= ctl_valid & (kind != K_NONE);
            ctl_ack     <= ctl_valid & kind_ack;
        end
    end

endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int PIN_W  = 3,
    localparam int CTL_W = PIN_W + 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_lock,
    input logic              ctl_valid,
    input logic [CTL_W-1:0]  ctl_byte,
    input logic              frame_stop,
    input logic              wr_req,
    input logic [ADDR_W-1:0] word_addr,
    input logic              mem_we,
    input logic              ctl_ack_vld,
    input logic              ctl_ack,
    input logic              perm_flag,
    input logic              rev_flag
);

    logic fam;
    assign fam = ctl_valid && (ctl_byte[CTL_W-1:CTL_W-4] == 4'b0110);

    p_pin_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock |-> !mem_we);

    p_lower_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_flag || rev_flag) && !word_addr[ADDR_W-1] |-> !mem_we);

    p_upper_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !hw_lock && word_addr[ADDR_W-1] |-> mem_we);

    p_perm_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        perm_flag |=> perm_flag);

    p_perm_silences_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fam && perm_flag |=> ctl_ack_vld && !ctl_ack);

    p_rev_reset_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid && ctl_byte == 8'h62 && rev_flag |=> !ctl_ack);

    p_pin_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock && frame_stop |=> $stable(perm_flag) && $stable(rev_flag));

    p_stop_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stop |=> $stable(perm_flag) && $stable(rev_flag));

    p_no_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fam |=> !ctl_ack_vld && !ctl_ack);

    p_resp_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fam |=> ctl_ack_vld);

endmodule

bind wprot_ctrl wprot_ctrl_chk #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_lock     (hw_lock),
    .ctl_valid   (ctl_valid),
    .ctl_byte    (ctl_byte),
    .frame_stop  (frame_stop),
    .wr_req      (wr_req),
    .word_addr   (word_addr),
    .mem_we      (mem_we),
    .ctl_ack_vld (ctl_ack_vld),
    .ctl_ack     (ctl_ack),
    .perm_flag   (perm_flag),
    .rev_flag    (rev_flag)
);

// File: tb/wprot_ctrl_tb_top.sv
`timescale 1ns/1ps
module wprot_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       preload_perm = 1'b0, preload_rev = 1'b0;
    logic       hw_lock = 1'b0, a0_hv = 1'b0;
    logic [2:0] pin_addr = 3'b101;
    logic       ctl_valid = 1'b0;
    logic [7:0] ctl_byte = 8'h00;
    logic       frame_start = 1'b0, frame_stop = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] word_addr = 8'h00;
    logic       mem_we, ctl_ack_vld, ctl_ack, perm_flag, rev_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wprot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .preload_perm(preload_perm), .preload_rev(preload_rev),
        .hw_lock(hw_lock), .a0_hv(a0_hv), .pin_addr(pin_addr), .ctl_valid(ctl_valid),
        .ctl_byte(ctl_byte), .frame_start(frame_start), .frame_stop(frame_stop),
        .wr_req(wr_req), .word_addr(word_addr), .mem_we(mem_we), .ctl_ack_vld(ctl_ack_vld),
        .ctl_ack(ctl_ack), .perm_flag(perm_flag), .rev_flag(rev_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    // kinds: 0 none, 1 miss, 2 set perm, 3 read perm, 4 set rev, 5 read rev, 6 clear rev
    function automatic int classify(logic [7:0] b, logic [2:0] p, logic hv);
        if (b[7:4] != 4'h6) return 0;
        if (hv) begin
            if (b == 8'h62 && p[2:1] == 2'b00) return 4;
            if (b == 8'h63 && p[2:1] == 2'b00) return 5;
            if (b == 8'h66 && p[2:1] == 2'b01) return 6;
            return 1;
        end
        if (b[3:1] == p) return b[0] ? 3 : 2;
        return 1;
    endfunction

    function automatic bit ack_of(int k, bit p, bit r);
        if (k == 2 || k == 3 || k == 6) return !p;
        if (k == 4 || k == 5) return !p && !r;
        return 0;
    endfunction

    bit m_perm, m_rev, e_vld, e_ack;
    int m_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_perm = preload_perm; m_rev = preload_rev;
            m_pend = 0; e_vld = 0; e_ack = 0;
        end else begin
            automatic int  k = classify(ctl_byte, pin_addr, a0_hv);
            automatic bit  a = ack_of(k, m_perm, m_rev);
            e_vld = ctl_valid && (k != 0);
            e_ack = ctl_valid && a;
            if (frame_stop) begin
                if (!hw_lock) begin
                    if (m_pend == 2) m_perm = 1;
                    if (m_pend == 4) m_rev = 1;
                    if (m_pend == 6) m_rev = 0;
                end
                m_pend = 0;
            end else if (frame_start) begin
                m_pend = 0;
            end else if (ctl_valid) begin
                m_pend = (a && (k == 2 || k == 4 || k == 6)) ? k : 0;
            end
        end
    end

    // Per-clock comparison, away from both edges
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            automatic bit e_we = wr_req && !hw_lock && !((m_perm || m_rev) && word_addr < 8'h80);
            check(mem_we == e_we, "R1/R2/R3 mem_we", mem_we, e_we);
            check(ctl_ack_vld == e_vld, "R11/R13 ctl_ack_vld", ctl_ack_vld, e_vld);
            check(ctl_ack == e_ack, "R5/R6/R7/R8 ctl_ack", ctl_ack, e_ack);
            check(perm_flag == m_perm, "R4/R10 perm_flag", perm_flag, m_perm);
            check(rev_flag == m_rev, "R6/R7/R9/R10 rev_flag", rev_flag, m_rev);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_frame(input logic [7:0] b, input bit close, output bit vld, output bit ack);
        @(negedge clk) frame_start = 1;
        @(negedge clk) frame_start = 0; ctl_valid = 1; ctl_byte = b;
        @(negedge clk) vld = ctl_ack_vld; ack = ctl_ack; ctl_valid = 0;
        repeat (2) @(negedge clk);
        if (close) begin
            frame_stop = 1;
            @(negedge clk) frame_stop = 0;
        end
        @(negedge clk);
    endtask

    task automatic write_at(input logic [7:0] a, output bit we);
        @(negedge clk) wr_req = 1; word_addr = a;
        #1 we = mem_we;
        @(negedge clk) wr_req = 0;
    endtask

    initial begin
        bit v, k, w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(perm_flag == 0 && rev_flag == 0, "R12 reset flags", {perm_flag, rev_flag}, 0);

        write_at(8'h10, w); check(w == 1, "R3 write 10h open", w, 1);
        write_at(8'h90, w); check(w == 1, "R3 write 90h open", w, 1);

        pin_addr = 3'b101;
        send_frame(8'h6B, 1, v, k); check(v && k, "R8 perm status unprogrammed", k, 1);
        a0_hv = 1; pin_addr = 3'b000;
        send_frame(8'h63, 1, v, k); check(v && k, "R8 rev status unprogrammed", k, 1);

        hw_lock = 1;
        send_frame(8'h62, 1, v, k); check(k == 1, "R9 set rev acked under pin", k, 1);
        check(rev_flag == 0, "R9 rev unchanged under pin", rev_flag, 0);
        hw_lock = 0;

        send_frame(8'h62, 1, v, k); check(k == 1, "R6 set rev ack", k, 1);
        check(rev_flag == 1, "R6 rev set at stop", rev_flag, 1);
        write_at(8'h10, w); check(w == 0, "R2 10h blocked", w, 0);
        write_at(8'h7F, w); check(w == 0, "R2 7Fh blocked", w, 0);
        write_at(8'h80, w); check(w == 1, "R2 80h open", w, 1);
        send_frame(8'h63, 1, v, k); check(v && !k, "R8 rev status programmed", k, 0);
        send_frame(8'h62, 1, v, k); check(v && !k, "R6 repeat set nack", k, 0);

        hw_lock = 1;
        write_at(8'h90, w); check(w == 0, "R1 pin blocks 90h", w, 0);
        hw_lock = 0;

        pin_addr = 3'b010;
        send_frame(8'h66, 1, v, k); check(k == 1, "R7 clear rev ack", k, 1);
        check(rev_flag == 0, "R7 rev cleared", rev_flag, 0);
        send_frame(8'h67, 1, v, k); check(v && !k, "R11 67h nack", k, 0);

        pin_addr = 3'b000;
        send_frame(8'h62, 0, v, k);
        send_frame(8'hA0, 0, v, k); check(!v, "R11 other nibble no response", v, 0);
        @(negedge clk) frame_stop = 1;
        @(negedge clk) frame_stop = 0;
        @(negedge clk);
        check(rev_flag == 0, "R10 aborted frame no change", rev_flag, 0);

        a0_hv = 0; pin_addr = 3'b101;
        send_frame(8'h60, 1, v, k); check(v && !k, "R11 address miss nack", k, 0);
        send_frame(8'h6A, 1, v, k); check(v && k, "R4 set perm ack", k, 1);
        check(perm_flag == 1, "R4 perm set", perm_flag, 1);
        write_at(8'h20, w); check(w == 0, "R2 perm blocks 20h", w, 0);

        send_frame(8'h6B, 1, v, k); check(v && !k, "R5 status nack", k, 0);
        send_frame(8'h6A, 1, v, k); check(v && !k, "R5 set perm nack", k, 0);
        a0_hv = 1; pin_addr = 3'b010;
        send_frame(8'h66, 1, v, k); check(v && !k, "R5 clear rev nack", k, 0);
        pin_addr = 3'b000;
        send_frame(8'h62, 1, v, k); check(v && !k, "R5 set rev nack", k, 0);
        check(perm_flag == 1 && rev_flag == 0, "R4 perm sticky", {perm_flag, rev_flag}, 2);
        a0_hv = 0;

        preload_perm = 1; preload_rev = 1;
        @(negedge clk) rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(perm_flag == 1 && rev_flag == 1, "R12 preload loaded", {perm_flag, rev_flag}, 3);

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule